// File: doc/BRIEF.md
# Configurable External Interrupt Conditioner

This block turns pins of a small input port into interrupt requests for a two-level interrupt arbiter. It has several independent request channels, two by default. Each channel picks one port bit at run time and applies its own choice of active level. It then reports either a held level request or a latched edge request. The pins are only sampled, so a channel can watch a pin that another peripheral is using without disturbing it.

Software programs the block through a small write/read register port. A selection register holds one pin index and one polarity bit for each channel. A mode register holds one bit per channel that chooses edge or level detection. A priority register holds one bit per channel that sets the tag the channel presents to the arbiter. Each channel has an acknowledge input that the arbiter pulses when it services a latched edge. A two-flop synchronizer sits in front of pin selection. A change of pin or polarity is kept from producing a false edge.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, every register reads 0x00. Every channel then watches pin 0, treats it as active low, works in level mode, and presents a low priority tag (`irq_hi` = 0).
- R2: Selection register (address 0) gives channel k bits [4k+2:4k], and this field is the index of the port bit the channel watches.
- R3: Bit 4k+3 of the selection register sets the polarity of channel k: 1 means active high and 0 means active low.
- R4: When bit k of the mode register (address 1) is 0, the channel is in level mode. `irq_req[k]` then follows the active level of its pin, two clock edges after the pin changes. `irq_ack[k]` has no effect in this mode.
- R5: When bit k of the mode register is 1, the channel is in edge mode. An inactive-to-active transition of the pin sets `irq_req[k]` three clock edges after the pin changes. The request stays set when the pin returns to inactive, and a one-cycle `irq_ack[k]` clears it.
- R6: In edge mode, if a new active-going edge and `irq_ack[k]` arrive in the same cycle, the request stays set.
- R7: A selection-register write that changes a channel's pin or polarity does not report an edge, even when the newly selected input is already active. Later genuine edges are still caught.
- R8: Bit k of the priority register (address 2) drives `irq_hi[k]`: 0 is low priority and 1 is high priority.
- R9: In the mode and priority registers, bits above the channel count read 0 and ignore writes. Address 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 selection, 1 mode, 2 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| port_in | input | 8 | Port pins, sampled only |
| irq_ack | input | 2 | Per-channel acknowledge pulse |
| irq_req | output | 2 | Per-channel interrupt request |
| irq_hi | output | 2 | Per-channel priority tag, 1 = high |

## Verification
The bench builds the block with its default parameters: an 8-bit port, two channels and two synchronizer stages. With these values every 3-bit pin field and the 4-bit channel packing are used. Both channels can be set to different pins, polarities and modes at the same time. The exact two-edge and three-edge latencies of the level path and the edge path can be sampled cycle by cycle. Because the channel count is smaller than the register width, the unused high bits of the mode and priority registers can be written and then read back.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic [1:0] {
      RA_SEL  = 2'd0,
      RA_MODE = 2'd1,
      RA_PRIO = 2'd2,
      RA_NONE = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("ext_irq_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '1;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
#(
   parameter int N_SRC = 2,
   parameter int FLD_W = 4,
   parameter int REG_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [1:0]             addr,
   input  logic [REG_W-1:0]       wdata,
   output logic [REG_W-1:0]       rdata,
   output logic [N_SRC*FLD_W-1:0] sel_cfg,
   output logic [N_SRC-1:0]       mode,
   output logic [N_SRC-1:0]       prio,
   output logic [N_SRC-1:0]       cfg_chg
);
   localparam int CFG_W = N_SRC * FLD_W;

   if (CFG_W > REG_W) begin : g_bad_pack
      $error("ext_irq_regs: selection fields do not fit the register");
   end

   reg_addr_e a;
   logic      wr_sel, wr_mode, wr_prio;
   assign a       = reg_addr_e'(addr);
   assign wr_sel  = we && (a == RA_SEL);
   assign wr_mode = we && (a == RA_MODE);
   assign wr_prio = we && (a == RA_PRIO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_cfg <= '0;
         mode    <= '0;
         prio    <= '0;
      end else begin
         if (wr_sel)  sel_cfg <= wdata[CFG_W-1:0];
         if (wr_mode) mode    <= wdata[N_SRC-1:0];
         if (wr_prio) prio    <= wdata[N_SRC-1:0];
      end
   end

   for (genvar k = 0; k < N_SRC; k++) begin : g_chg
      assign cfg_chg[k] = wr_sel &&
         (wdata[k*FLD_W +: FLD_W] != sel_cfg[k*FLD_W +: FLD_W]);
   end

   always_comb begin
      rdata = '0;
      case (a)
         RA_SEL:  rdata[CFG_W-1:0] = sel_cfg;
         RA_MODE: rdata[N_SRC-1:0] = mode;
         RA_PRIO: rdata[N_SRC-1:0] = prio;
         default: rdata = '0;
      endcase
   end

   // R8: a priority write lands in the tag on the next cycle
   p_prio_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_prio |=> (prio == $past(wdata[N_SRC-1:0])));
   // R9: unused bits of the priority register read as zero
   p_prio_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a == RA_PRIO) |-> ((rdata >> N_SRC) == '0));
   // R9: the hole at address 3 reads zero
   p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a == RA_NONE) |-> (rdata == '0));
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan #(
   parameter int PORT_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pins_s,
   input  logic [SEL_W-1:0]  sel,
   input  logic              pol_hi,
   input  logic              edge_mode,
   input  logic              cfg_chg,
   input  logic              ack,
   output logic              req
);
   logic active, prev, hist_vld, pend, edge_now;

   assign active   = pol_hi ? pins_s[sel] : ~pins_s[sel];
   assign edge_now = hist_vld && active && !prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= 1'b0;
         hist_vld <= 1'b0;
         pend     <= 1'b0;
      end else begin
         prev     <= active;
         hist_vld <= !cfg_chg;
         if (edge_mode) pend <= (pend && !ack) || edge_now;
         else           pend <= 1'b0;
      end
   end

   assign req = edge_mode ? pend : active;

   // R5: a latched request is held until acknowledged
   p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && pend && !ack) |=> pend);
   // R5: an acknowledge without a new edge clears the request
   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && ack && !edge_now) |=> !pend);
   // R6: a new edge wins over a coincident acknowledge
   p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && edge_now) |=> pend);
   // R7: no edge is reported in the cycle after a pin/polarity change
   p_no_false_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg |=> !edge_now);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
   parameter int PORT_W      = 8,
   parameter int N_SRC       = 2,
   parameter int REG_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [PORT_W-1:0] port_in,
   input  logic [N_SRC-1:0]  irq_ack,
   output logic [N_SRC-1:0]  irq_req,
   output logic [N_SRC-1:0]  irq_hi
);
   localparam int SEL_W = $clog2(PORT_W);
   localparam int FLD_W = SEL_W + 1;

   if (PORT_W < 2 || (1 << SEL_W) != PORT_W) begin : g_bad_port
      $error("ext_irq_cond: PORT_W must be a power of two of at least 2");
   end
   if (N_SRC < 1 || N_SRC > REG_W) begin : g_bad_src
      $error("ext_irq_cond: N_SRC out of range");
   end

   logic [PORT_W-1:0]      pins_s;
   logic [N_SRC*FLD_W-1:0] sel_cfg;
   logic [N_SRC-1:0]       mode, cfg_chg;

   ext_irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(port_in), .q(pins_s)
   );

   ext_irq_regs #(.N_SRC(N_SRC), .FLD_W(FLD_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .sel_cfg(sel_cfg),
      .mode(mode), .prio(irq_hi), .cfg_chg(cfg_chg)
   );

   for (genvar k = 0; k < N_SRC; k++) begin : g_chan
      ext_irq_chan #(.PORT_W(PORT_W), .SEL_W(SEL_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .pins_s(pins_s),
         .sel(sel_cfg[k*FLD_W +: SEL_W]),
         .pol_hi(sel_cfg[k*FLD_W + SEL_W]),
         .edge_mode(mode[k]), .cfg_chg(cfg_chg[k]),
         .ack(irq_ack[k]), .req(irq_req[k])
      );
   end

   // R4: in level mode an acknowledge leaves the request untouched
   p_level_ack_noeffect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[0] && irq_ack[0] && $stable(pins_s) && !cfg_chg[0] && !reg_we)
      |=> $stable(irq_req[0]));
endmodule

// File: tb/ext_irq_cond_tb.sv
module ext_irq_cond_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [7:0] port_in = 8'hFF;
   logic [1:0] irq_ack = 2'b00;
   logic [1:0] irq_req, irq_hi;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ext_irq_cond u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_in(port_in),
      .irq_ack(irq_ack), .irq_req(irq_req), .irq_hi(irq_hi)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse_ack(input logic [1:0] m);
      @(negedge clk); irq_ack = m;
      @(negedge clk); irq_ack = 2'b00;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         check(v, 8'h00, "R1 register reset value");
      end
      check({6'd0, irq_hi}, 8'h00, "R1 priority tag after reset");
      check({6'd0, irq_req}, 8'h00, "R1 no request with pin0 high");
      port_in = 8'hFE;
      cyc(3);
      check({6'd0, irq_req}, 8'h03, "R1 pin0 active low level request");
      port_in = 8'hFF;
      cyc(3);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      wr(2'd2, 8'h02);
      check({6'd0, irq_hi}, 8'h02, "R8 priority channel1 high");
      wr(2'd2, 8'hFD);
      rd(2'd2, v);
      check(v, 8'h01, "R9 priority unused bits read zero");
      check({6'd0, irq_hi}, 8'h01, "R8 priority channel0 high");
      wr(2'd1, 8'hFC);
      rd(2'd1, v);
      check(v, 8'h00, "R9 mode unused bits ignore writes");
      wr(2'd3, 8'hA5);
      rd(2'd3, v);
      check(v, 8'h00, "R9 address 3 reads zero");
      wr(2'd0, 8'hA5);
      rd(2'd0, v);
      check(v, 8'hA5, "R2 selection register readback");
   endtask

   task automatic t_level;
      // ch0: pin5 active high; ch1: pin2 active low; both level
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h2D);
      port_in = 8'h00;
      cyc(4);
      check({6'd0, irq_req}, 8'h02, "R2 R3 pin and polarity selection");
      port_in = 8'h20;
      cyc(1);
      check({7'd0, irq_req[0]}, 8'h00, "R4 level not yet after one edge");
      cyc(1);
      check({7'd0, irq_req[0]}, 8'h01, "R4 level after two edges");
      pulse_ack(2'b11);
      check({6'd0, irq_req}, 8'h03, "R4 ack has no effect in level mode");
      port_in = 8'h04;
      cyc(3);
      check({6'd0, irq_req}, 8'h00, "R4 R3 request drops with level");
   endtask

   task automatic t_edge;
      // ch0: pin3 active high edge; ch1: pin2 active low level
      port_in = 8'h04;
      wr(2'd0, 8'h2B);
      wr(2'd1, 8'h01);
      cyc(3);
      check({7'd0, irq_req[0]}, 8'h00, "R5 idle edge channel");
      port_in = 8'h0C;
      cyc(2);
      check({7'd0, irq_req[0]}, 8'h00, "R5 edge not yet after two edges");
      cyc(1);
      check({7'd0, irq_req[0]}, 8'h01, "R5 edge latched after three edges");
      port_in = 8'h04;
      cyc(4);
      check({7'd0, irq_req[0]}, 8'h01, "R5 request sticky after pin release");
      pulse_ack(2'b01);
      check({7'd0, irq_req[0]}, 8'h00, "R5 ack clears request");
      // re-latch, release, then new edge coincident with ack
      port_in = 8'h0C; cyc(4);
      port_in = 8'h04; cyc(4);
      check({7'd0, irq_req[0]}, 8'h01, "R5 relatched request");
      port_in = 8'h0C;
      cyc(2);
      irq_ack = 2'b01;
      cyc(1);
      irq_ack = 2'b00;
      check({7'd0, irq_req[0]}, 8'h01, "R6 edge wins over coincident ack");
      pulse_ack(2'b01);
      check({7'd0, irq_req[0]}, 8'h00, "R6 later ack clears");
      port_in = 8'h04; cyc(3);
   endtask

   task automatic t_cfg_change;
      // ch0 edge, pin0 active low; pin0 high, pin1 low
      wr(2'd0, 8'h20);
      port_in = 8'h05;
      cyc(4);
      pulse_ack(2'b01);
      check({7'd0, irq_req[0]}, 8'h00, "R7 clean start");
      wr(2'd0, 8'h21);
      cyc(4);
      check({7'd0, irq_req[0]}, 8'h00, "R7 no false edge on pin change");
      port_in = 8'h07; cyc(4);
      port_in = 8'h05; cyc(4);
      check({7'd0, irq_req[0]}, 8'h01, "R7 real edge after change caught");
      pulse_ack(2'b01);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_regs();
      t_level();
      t_edge();
      t_cfg_change();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule